// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Busy Flags

This block is a clocked memory shared by two independent ports, called left and right. Each port can read or write any word in any cycle. Each port has its own enable, direction, output-enable, per-byte lane selects, address and separate input and output data buses. A per-lane valid vector replaces three-state pins: a lane that is not driven reads as zero and has its valid bit cleared. Read results appear on the registered outputs one clock after the request is sampled.

When both ports select the same word in the same cycle, an arbiter grants the left port. It flags the right port busy and drops the right port's write for that cycle. The default address width gives a 1K-word array. Setting `ADDR_W` to 14 gives the full 16K x 16 organisation. A strap input selects the device role for width cascading. A master device produces its busy flags from its own arbiter. A slave device takes busy inputs from a master: a low busy input blocks that port's writes, and the slave's own busy outputs stay idle high.

Top module: `twin_port_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of 16 bits. A word written by one port reads back on either port, with data and valid appearing after the clock edge following the sampled read request.
- R2: A port takes part in a memory access only while its enable is low and its semaphore select is high. Otherwise its writes are ignored, it causes no collision, and its next output has valid 00 and data zero.
- R3: A write (direction low) updates bits [15:8] when the upper select is low and bits [7:0] when the lower select is low. An unselected lane keeps its content.
- R4: A read (direction high, output enable low) sets valid bit 1 (upper lane) when the upper select is low and valid bit 0 (lower lane) when the lower select is low. An invalid lane's data is zero.
- R5: With output enable high, or with both lane selects high, a port returns valid 00 even while enabled.
- R6: In master mode (strap high), two active ports on the same address in one cycle form a collision. The right busy output goes low in the next cycle, and the left busy output stays high.
- R7: A busy output returns high in the cycle after the collision ends.
- R8: A port that loses arbitration has its write dropped. A read by the losing port still returns the word stored before that cycle.
- R9: In slave mode (strap low), a low busy input blocks that port's write in the same cycle. No collision flag is generated, and both busy outputs stay high.
- R10: A synchronous active-high reset clears both valid vectors and sets both busy outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_master | input | 1 | 1 = master (busy generated), 0 = slave (busy received) |
| l_ce_n | input | 1 | Left enable, active low |
| l_rw | input | 1 | Left direction, 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper-lane select, active low |
| l_lb_n | input | 1 | Left lower-lane select, active low |
| l_sem_n | input | 1 | Left semaphore select, must be high for memory access |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | 16 | Left write data |
| l_busy_in_n | input | 1 | Left busy from a master, used in slave mode |
| l_dout | output | 16 | Left read data, zero on invalid lanes |
| l_dvalid | output | 2 | Left lane valid, bit 1 upper, bit 0 lower |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_ce_n | input | 1 | Right enable, active low |
| r_rw | input | 1 | Right direction, 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper-lane select, active low |
| r_lb_n | input | 1 | Right lower-lane select, active low |
| r_sem_n | input | 1 | Right semaphore select, must be high for memory access |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | 16 | Right write data |
| r_busy_in_n | input | 1 | Right busy from a master, used in slave mode |
| r_dout | output | 16 | Right read data, zero on invalid lanes |
| r_dvalid | output | 2 | Right lane valid, bit 1 upper, bit 0 lower |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
Disjoint-address traffic on both ports shows that each port reaches the whole array and sees the other port's writes. Single-lane writes followed by full-word reads show lane isolation. Same-address pairs are tried as write/write, read/read and enabled-but-idle: the first shows that the right write is dropped, the second that a losing read still returns data, and the third that a collision needs only enables, not data movement. Semaphore-select and deselected writes, slave-mode blocked writes, and reads with output enable or lane selects off confirm that each gating term acts alone.

// File: rtl/twin_port_ram_pkg.sv
package twin_port_ram_pkg;
  localparam int LANES = 2;
  localparam int LANE_UP = 1;
  localparam int LANE_LO = 0;

  typedef struct packed {
    logic ce_n;
    logic rw;
    logic oe_n;
    logic ub_n;
    logic lb_n;
    logic sem_n;
  } port_ctl_t;
endpackage

// File: rtl/tpr_lane_mem.sv
module tpr_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANE_W-1:0] a_din,
  output logic [LANE_W-1:0] a_q,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANE_W-1:0] b_din,
  output logic [LANE_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // read-first on both ports; the arbiter keeps both writes off one word
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_din;
    if (b_we) mem[b_addr] <= b_din;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/tpr_port_ctrl.sv
module tpr_port_ctrl
  import twin_port_ram_pkg::*;
(
  input  port_ctl_t        ctl,
  input  logic             blocked,
  output logic             active,
  output logic [LANES-1:0] lane_we,
  output logic [LANES-1:0] rd_mask
);
  logic [LANES-1:0] lane_sel;
  logic             wr_ok;
  logic             rd_ok;

  always_comb begin
    active            = !ctl.ce_n && ctl.sem_n;
    lane_sel[LANE_UP] = !ctl.ub_n;
    lane_sel[LANE_LO] = !ctl.lb_n;
    wr_ok             = active && !ctl.rw && !blocked;
    rd_ok             = active && ctl.rw && !ctl.oe_n;
    lane_we           = wr_ok ? lane_sel : '0;
    rd_mask           = rd_ok ? lane_sel : '0;
  end
endmodule

// File: rtl/tpr_arbiter.sv
module tpr_arbiter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_master,
  input  logic              l_active,
  input  logic              r_active,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_block,
  output logic              r_block,
  output logic              l_busy_n,
  output logic              r_busy_n
);
  logic collide;

  always_comb begin
    collide = l_active && r_active && (l_addr == r_addr);
    if (ms_master) begin
      l_block = 1'b0;
      r_block = collide;
    end else begin
      l_block = !l_busy_in_n;
      r_block = !r_busy_in_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_busy_n <= 1'b1;
      r_busy_n <= 1'b1;
    end else begin
      l_busy_n <= !(ms_master && l_block);
      r_busy_n <= !(ms_master && r_block);
    end
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ms_master,
  input  logic                  l_ce_n,
  input  logic                  l_rw,
  input  logic                  l_oe_n,
  input  logic                  l_ub_n,
  input  logic                  l_lb_n,
  input  logic                  l_sem_n,
  input  logic [ADDR_W-1:0]     l_addr,
  input  logic [2*LANE_W-1:0]   l_din,
  input  logic                  l_busy_in_n,
  output logic [2*LANE_W-1:0]   l_dout,
  output logic [1:0]            l_dvalid,
  output logic                  l_busy_n,
  input  logic                  r_ce_n,
  input  logic                  r_rw,
  input  logic                  r_oe_n,
  input  logic                  r_ub_n,
  input  logic                  r_lb_n,
  input  logic                  r_sem_n,
  input  logic [ADDR_W-1:0]     r_addr,
  input  logic [2*LANE_W-1:0]   r_din,
  input  logic                  r_busy_in_n,
  output logic [2*LANE_W-1:0]   r_dout,
  output logic [1:0]            r_dvalid,
  output logic                  r_busy_n
);
  port_ctl_t        l_ctl, r_ctl;
  logic             l_active, r_active, l_block, r_block;
  logic [LANES-1:0] l_we, r_we, l_mask, r_mask;
  logic [LANES-1:0] l_vld_q, r_vld_q;
  logic [LANE_W-1:0] l_q [LANES];
  logic [LANE_W-1:0] r_q [LANES];

  assign l_ctl = '{ce_n: l_ce_n, rw: l_rw, oe_n: l_oe_n,
                   ub_n: l_ub_n, lb_n: l_lb_n, sem_n: l_sem_n};
  assign r_ctl = '{ce_n: r_ce_n, rw: r_rw, oe_n: r_oe_n,
                   ub_n: r_ub_n, lb_n: r_lb_n, sem_n: r_sem_n};

  tpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst), .ms_master(ms_master),
    .l_active(l_active), .r_active(r_active),
    .l_addr(l_addr), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_block(l_block), .r_block(r_block),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n)
  );

  tpr_port_ctrl u_lctl (
    .ctl(l_ctl), .blocked(l_block), .active(l_active),
    .lane_we(l_we), .rd_mask(l_mask)
  );

  tpr_port_ctrl u_rctl (
    .ctl(r_ctl), .blocked(r_block), .active(r_active),
    .lane_we(r_we), .rd_mask(r_mask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tpr_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk(clk),
      .a_we(l_we[g]), .a_addr(l_addr), .a_din(l_din[g*LANE_W +: LANE_W]),
      .a_q(l_q[g]),
      .b_we(r_we[g]), .b_addr(r_addr), .b_din(r_din[g*LANE_W +: LANE_W]),
      .b_q(r_q[g])
    );
    assign l_dout[g*LANE_W +: LANE_W] = l_vld_q[g] ? l_q[g] : '0;
    assign r_dout[g*LANE_W +: LANE_W] = r_vld_q[g] ? r_q[g] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_vld_q <= '0;
      r_vld_q <= '0;
    end else begin
      l_vld_q <= l_mask;
      r_vld_q <= r_mask;
    end
  end

  assign l_dvalid = l_vld_q;
  assign r_dvalid = r_vld_q;
endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ms_master,
  input logic              l_ce_n,
  input logic              l_oe_n,
  input logic              l_ub_n,
  input logic              l_sem_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic [1:0]        l_dvalid,
  input logic              l_busy_n,
  input logic              r_ce_n,
  input logic              r_sem_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic [1:0]        r_dvalid,
  input logic              r_busy_n
);
  logic both_same;
  assign both_same = !l_ce_n && l_sem_n && !r_ce_n && r_sem_n && (l_addr == r_addr);

  AST_DESELECT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (l_ce_n || !l_sem_n) |=> (l_dvalid == 2'b00)); // R2
  AST_UPPER_LANE_GATED: assert property (@(posedge clk) disable iff (rst)
    l_ub_n |=> !l_dvalid[1]); // R4
  AST_OE_OFF_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    l_oe_n |=> (l_dvalid == 2'b00)); // R5
  AST_RIGHT_LOSES: assert property (@(posedge clk) disable iff (rst)
    (ms_master && both_same) |=> !r_busy_n); // R6
  AST_LEFT_NEVER_BUSY: assert property (@(posedge clk) disable iff (rst)
    ms_master |=> l_busy_n); // R6
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !both_same |=> r_busy_n); // R7
  AST_SLAVE_IDLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ms_master |=> (l_busy_n && r_busy_n)); // R9
  AST_RIGHT_DESELECT: assert property (@(posedge clk) disable iff (rst)
    r_ce_n |=> (r_dvalid == 2'b00)); // R2
endmodule

bind twin_port_ram twin_port_ram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_twin_port_ram.sv
module test_twin_port_ram;
  localparam int AW = 10;

  // control field order {ce_n, rw, oe_n, ub_n, lb_n, sem_n}
  localparam logic [5:0] IDLE     = 6'b111111;
  localparam logic [5:0] WR_BOTH  = 6'b001001;
  localparam logic [5:0] WR_UP    = 6'b001011;
  localparam logic [5:0] WR_LO    = 6'b001101;
  localparam logic [5:0] RD_BOTH  = 6'b010001;
  localparam logic [5:0] RD_UP    = 6'b010011;
  localparam logic [5:0] RD_LO    = 6'b010101;
  localparam logic [5:0] RD_OEOFF = 6'b011001;
  localparam logic [5:0] RD_NOSEL = 6'b010111;
  localparam logic [5:0] SEM_WR   = 6'b001000;
  localparam logic [5:0] SEM_RD   = 6'b010000;
  localparam logic [5:0] DES_WR   = 6'b101001;

  typedef struct packed {
    logic [5:0]    lc;
    logic [AW-1:0] la;
    logic [15:0]   ld;
    logic [5:0]    rc;
    logic [AW-1:0] ra;
    logic [15:0]   rd;
    logic [15:0]   eld;
    logic [1:0]    elv;
    logic [15:0]   erd;
    logic [1:0]    erv;
    logic          erb;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{WR_BOTH, 10'd5, 16'hA1B2, WR_BOTH, 10'd9, 16'hC3D4, 16'h0000, 2'b00, 16'h0000, 2'b00, 1'b1, 4'd1},  // R1
    '{RD_BOTH, 10'd9, 16'h0000, RD_BOTH, 10'd5, 16'h0000, 16'hC3D4, 2'b11, 16'hA1B2, 2'b11, 1'b1, 4'd1},  // R1
    '{WR_UP,   10'd5, 16'hEEFF, IDLE,    10'd0, 16'h0000, 16'h0000, 2'b00, 16'h0000, 2'b00, 1'b1, 4'd3},  // R3
    '{RD_BOTH, 10'd5, 16'h0000, WR_LO,   10'd9, 16'h1122, 16'hEEB2, 2'b11, 16'h0000, 2'b00, 1'b1, 4'd3},  // R3
    '{RD_UP,   10'd9, 16'h0000, RD_LO,   10'd9, 16'h0000, 16'hC300, 2'b10, 16'h0022, 2'b01, 1'b0, 4'd4},  // R4 R6 R8
    '{WR_BOTH, 10'd7, 16'h5555, WR_BOTH, 10'd7, 16'h6666, 16'h0000, 2'b00, 16'h0000, 2'b00, 1'b0, 4'd6},  // R6
    '{RD_BOTH, 10'd7, 16'h0000, IDLE,    10'd0, 16'h0000, 16'h5555, 2'b11, 16'h0000, 2'b00, 1'b1, 4'd8},  // R8 R7
    '{RD_OEOFF,10'd7, 16'h0000, RD_NOSEL,10'd7, 16'h0000, 16'h0000, 2'b00, 16'h0000, 2'b00, 1'b0, 4'd5},  // R5
    '{IDLE,    10'd0, 16'h0000, SEM_WR,  10'd7, 16'h7777, 16'h0000, 2'b00, 16'h0000, 2'b00, 1'b1, 4'd7},  // R7
    '{SEM_RD,  10'd7, 16'h0000, RD_BOTH, 10'd7, 16'h0000, 16'h0000, 2'b00, 16'h5555, 2'b11, 1'b1, 4'd2},  // R2
    '{DES_WR,  10'd7, 16'h0000, IDLE,    10'd0, 16'h0000, 16'h0000, 2'b00, 16'h0000, 2'b00, 1'b1, 4'd2},  // R2
    '{RD_BOTH, 10'd7, 16'h0000, IDLE,    10'd0, 16'h0000, 16'h5555, 2'b11, 16'h0000, 2'b00, 1'b1, 4'd2}   // R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_master = 1'b1;
  logic [5:0] lc = IDLE, rc = IDLE;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_din = '0, r_din = '0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic [15:0] l_dout, r_dout;
  logic [1:0] l_dvalid, r_dvalid;
  logic l_busy_n, r_busy_n;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .LANE_W(8)) i_twin_port_ram (
    .clk(clk), .rst(rst), .ms_master(ms_master),
    .l_ce_n(lc[5]), .l_rw(lc[4]), .l_oe_n(lc[3]), .l_ub_n(lc[2]), .l_lb_n(lc[1]),
    .l_sem_n(lc[0]), .l_addr(l_addr), .l_din(l_din), .l_busy_in_n(l_busy_in_n),
    .l_dout(l_dout), .l_dvalid(l_dvalid), .l_busy_n(l_busy_n),
    .r_ce_n(rc[5]), .r_rw(rc[4]), .r_oe_n(rc[3]), .r_ub_n(rc[2]), .r_lb_n(rc[1]),
    .r_sem_n(rc[0]), .r_addr(r_addr), .r_din(r_din), .r_busy_in_n(r_busy_in_n),
    .r_dout(r_dout), .r_dvalid(r_dvalid), .r_busy_n(r_busy_n)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive after a falling edge, result visible at the following falling edge
  task automatic step(input logic [5:0] l_c, input logic [AW-1:0] la, input logic [15:0] ld,
                      input logic [5:0] r_c, input logic [AW-1:0] ra, input logic [15:0] rd);
    lc = l_c; l_addr = la; l_din = ld;
    rc = r_c; r_addr = ra; r_din = rd;
    @(negedge clk);
  endtask

  function automatic logic [39:0] outs();
    return {2'b00, l_dout, l_dvalid, r_dout, r_dvalid, l_busy_n, r_busy_n};
  endfunction

  function automatic logic [39:0] pack(input logic [15:0] ld, input logic [1:0] lv,
                                       input logic [15:0] rd, input logic [1:0] rv,
                                       input logic lb, input logic rb);
    return {2'b00, ld, lv, rd, rv, lb, rb};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset outputs", outs(), pack(16'h0, 2'b00, 16'h0, 2'b00, 1'b1, 1'b1));
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].lc, VECS[i].la, VECS[i].ld, VECS[i].rc, VECS[i].ra, VECS[i].rd);
      check($sformatf("vector %0d R%0d", i, VECS[i].req), outs(),
            pack(VECS[i].eld, VECS[i].elv, VECS[i].erd, VECS[i].erv, 1'b1, VECS[i].erb));
    end

    // seed words for the slave-mode tests
    step(WR_BOTH, 10'd4, 16'h1234, WR_BOTH, 10'd3, 16'h0F0F);

    // R9: slave mode, busy inputs low block both writes, busy outputs idle
    ms_master = 1'b0; l_busy_in_n = 1'b0; r_busy_in_n = 1'b0;
    step(WR_BOTH, 10'd4, 16'hFFFF, WR_BOTH, 10'd3, 16'hA5A5);
    check("R9 slave busy outputs", {38'h0, l_busy_n, r_busy_n}, {38'h0, 2'b11});
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;

    // R9: same-address reads in slave mode raise no busy; right write was blocked
    step(RD_BOTH, 10'd3, 16'h0, RD_BOTH, 10'd3, 16'h0);
    check("R9 slave collision and blocked right write", outs(),
          pack(16'h0F0F, 2'b11, 16'h0F0F, 2'b11, 1'b1, 1'b1));
    step(RD_BOTH, 10'd4, 16'h0, IDLE, 10'd0, 16'h0);
    check("R9 blocked left write", outs(), pack(16'h1234, 2'b11, 16'h0, 2'b00, 1'b1, 1'b1));

    // R8: master collision, right write dropped while left reads
    ms_master = 1'b1;
    step(RD_BOTH, 10'd4, 16'h0, WR_BOTH, 10'd4, 16'hDEAD);
    check("R8 losing write collision", outs(), pack(16'h1234, 2'b11, 16'h0, 2'b00, 1'b1, 1'b0));
    step(IDLE, 10'd0, 16'h0, RD_BOTH, 10'd4, 16'h0);
    check("R8 dropped write R7 release", outs(), pack(16'h0, 2'b00, 16'h1234, 2'b11, 1'b1, 1'b1));

    // R10: reset in mid-traffic clears valid and busy
    step(RD_BOTH, 10'd4, 16'h0, RD_BOTH, 10'd4, 16'h0);
    rst = 1'b1;
    step(RD_BOTH, 10'd4, 16'h0, RD_BOTH, 10'd4, 16'h0);
    check("R10 mid-run reset", outs(), pack(16'h0, 2'b00, 16'h0, 2'b00, 1'b1, 1'b1));
    rst = 1'b0;
    step(IDLE, 10'd0, 16'h0, IDLE, 10'd0, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule